// File: doc/BRIEF.md
# Per-Flow Round Assignment Unit

This block is the placement engine of a round-based fair packet scheduler that has no per-flow queues. The buffer is organised as a ring of round queues. For each arriving packet the block works out the round in which deficit round robin would send it, and returns that round as a queue index. The surrounding logic then links the packet into that queue. Packet storage, queue pointers and the output link are handled outside the block.

Each flow has one entry in a table. The entry holds the bytes the flow has queued, a signed carry-over credit, and the round in which the flow last sent a packet. Three kinds of event update the table. An arrival produces a queue index. A departure charges the packet against the flow's credit. A discard only removes bytes from the flow's backlog. Each flow's credit per round is its weight multiplied by the maximum packet size.

The table is a synchronous RAM, and each event is one read-modify-write. The ceiling division runs in a restoring divider that takes several cycles. While `busy` is high, the block accepts no new events. Events offered in the same cycle are applied one after another, in a fixed order.

Top module: `round_assign_unit`

## Requirements
- R1: The per-round credit of flow f is weight(f) × MAX_PKT. weight(f) is the unsigned field `weights[f*WT_W +: WT_W]`, with WT_W = clog2(MAX_W+1), and must be at least 1.
- R2: An arrival for a flow whose backlog is zero treats the flow as new. The backlog and credit start from zero, and the last-served round is set to the current round.
- R3: On an arrival or a departure for a flow that is not new, if the flow's last-served round differs from the current round and its credit is negative, the per-round credit is added once before the event is applied.
- R4: On an arrival the index is (round + max(ceil((backlog − credit + size) / quantum), 1) − 1) mod NUM_Q. NUM_Q is a power of two, so the sum wraps, and a non-positive numerator yields the current round.
- R5: After the index is formed, the arrival's size is added to the flow's backlog.
- R6: A departure subtracts its size from both backlog and credit, and records the current round as the flow's last-served round.
- R7: A discard reduces only the backlog. It leaves the credit and the last-served round unchanged.
- R8: Events accepted in the same cycle are applied in this order: departure first, then arrival, then discard.
- R9: Events and `cur_round` are sampled only in a cycle where `busy` is low, and `busy` is high in the next cycle. Requests made while `busy` is high are ignored.
- R10: `idx_valid` pulses for exactly one cycle for each accepted arrival. `busy` goes low no earlier than that cycle.
- R11: After reset `busy` and `idx_valid` are low and every flow is new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_round | input | clog2(NUM_Q) | Round queue now feeding the link |
| weights | input | NUM_FLOWS*WT_W | Packed per-flow weights |
| enq_req | input | 1 | Arrival event |
| enq_flow | input | clog2(NUM_FLOWS) | Arrival flow |
| enq_size | input | clog2(MAX_PKT+1) | Arrival size in bytes |
| deq_req | input | 1 | Departure event |
| deq_flow | input | clog2(NUM_FLOWS) | Departure flow |
| deq_size | input | clog2(MAX_PKT+1) | Departure size in bytes |
| drop_req | input | 1 | Discard event |
| drop_flow | input | clog2(NUM_FLOWS) | Discard flow |
| drop_size | input | clog2(MAX_PKT+1) | Discard size in bytes |
| busy | output | 1 | Events being processed; new requests ignored |
| idx_valid | output | 1 | One-cycle strobe for `idx_out` |
| idx_out | output | clog2(NUM_Q) | Round queue for the arrival |

## Verification
The hardest situations to reach are those where two events on the same flow in one cycle only differ in outcome if the fixed order is kept. One example is a departure that empties a flow while an arrival lands on that flow in the same cycle. Another is a topped-up credit larger than the backlog, which drives the numerator negative. The stimulus builds each flow's history with single events, moves the round counter between them, and then issues the combined events in one cycle. The sizes are chosen so that the wrong order, or a missing clamp, gives a different index or a different later index.

// File: rtl/rau_pkg.sv
package rau_pkg;

    // Enum value order is the service order for simultaneous events.
    typedef enum logic [1:0] {
        OP_DEQ  = 2'd0,
        OP_ENQ  = 2'd1,
        OP_DROP = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_DIV
    } st_e;

    function automatic op_e first_op(input logic [2:0] pend);
        if (pend[0]) return OP_DEQ;
        if (pend[1]) return OP_ENQ;
        return OP_DROP;
    endfunction

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rau_flow_table.sv
module rau_flow_table #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (we) mem[wr_addr] <= wr_data;
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/rau_divider.sv
module rau_divider #(
    parameter int W      = 17,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    logic [W:0]       rem;
    logic [W-1:0]     quo;
    logic [W-1:0]     dvs;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       rem_sh;
    logic             fits;

    always_comb begin
        rem_sh = {rem[W-1:0], quo[W-1]};
        fits   = (rem_sh >= {1'b0, dvs});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            quo  <= '0;
            dvs  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                quo  <= dividend;
                dvs  <= divisor;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                rem <= fits ? (rem_sh - {1'b0, dvs}) : rem_sh;
                quo <= {quo[W-2:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo;

    // R4: the remainder ends below the divisor, so the quotient is the floor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (done && dvs != '0) |-> (rem < {1'b0, dvs}));

    // R4: the result strobe only follows a running division
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/round_assign_unit.sv
module round_assign_unit
    import rau_pkg::*;
#(
    parameter int NUM_FLOWS = 8,
    parameter int NUM_Q     = 16,
    parameter int MAX_PKT   = 64,
    parameter int MAX_W     = 4,
    parameter int BYTES_W   = 16,
    localparam int FL_W     = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
    localparam int RND_W    = $clog2(NUM_Q),
    localparam int SIZE_W   = $clog2(MAX_PKT + 1),
    localparam int WT_W     = $clog2(MAX_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RND_W-1:0]          cur_round,
    input  logic [NUM_FLOWS*WT_W-1:0] weights,
    input  logic                      enq_req,
    input  logic [FL_W-1:0]           enq_flow,
    input  logic [SIZE_W-1:0]         enq_size,
    input  logic                      deq_req,
    input  logic [FL_W-1:0]           deq_flow,
    input  logic [SIZE_W-1:0]         deq_size,
    input  logic                      drop_req,
    input  logic [FL_W-1:0]           drop_flow,
    input  logic [SIZE_W-1:0]         drop_size,
    output logic                      busy,
    output logic                      idx_valid,
    output logic [RND_W-1:0]          idx_out
);

    localparam int Q_W   = $clog2(MAX_W * MAX_PKT + 1);
    localparam int DEF_W = Q_W + 1;
    localparam int N_W   = BYTES_W + 2;
    localparam int DIV_W = N_W - 1;

    typedef struct packed {
        logic [BYTES_W-1:0]      backlog;
        logic signed [DEF_W-1:0] deficit;
        logic [RND_W-1:0]        last_rnd;
    } fent_t;
    localparam int ENT_W = $bits(fent_t);

    generate
        if (!is_pow2(NUM_Q)) begin : g_bad_nq
            initial $error("NUM_Q must be a power of two");
        end
    endgenerate

    st_e               state;
    logic [2:0]        pend;
    logic [FL_W-1:0]   ev_flow [3];
    logic [SIZE_W-1:0] ev_size [3];
    logic [RND_W-1:0]  cur_lat;
    fent_t             hold;

    op_e               sel;
    logic [2:0]        sel_bit;
    logic              more;
    logic [ENT_W-1:0]  tbl_rd;
    logic [ENT_W-1:0]  tbl_wd;
    logic              tbl_we;
    fent_t             ent, upd, hold_w;
    logic [WT_W-1:0]   wt;
    logic [Q_W-1:0]    quantum;
    logic [SIZE_W-1:0] cur_size;
    logic signed [N_W-1:0] def_x, q_x, sz_x, bl_x, def_adj, def_enq, num;
    logic              fresh, topup;
    logic              div_start, div_busy, div_done;
    logic [DIV_W-1:0]  div_in, div_q;
    logic              accept;

    assign accept  = (state == ST_IDLE) && (enq_req || deq_req || drop_req);
    assign busy    = (state != ST_IDLE);
    assign sel     = first_op(pend);
    assign sel_bit = 3'(1) << sel;
    assign more    = |(pend & ~sel_bit);

    always_comb begin
        cur_size = ev_size[sel];
        wt       = weights[ev_flow[sel]*WT_W +: WT_W];
        quantum  = Q_W'(wt) * Q_W'(MAX_PKT);
        ent      = fent_t'(tbl_rd);
        def_x    = N_W'(ent.deficit);
        q_x      = $signed(N_W'(quantum));
        sz_x     = $signed(N_W'(cur_size));
        bl_x     = $signed(N_W'(ent.backlog));
        fresh    = (ent.backlog == '0);
        topup    = (ent.last_rnd != cur_lat) && (ent.deficit < 0);
        def_adj  = topup ? (def_x + q_x) : def_x;
        def_enq  = fresh ? '0 : def_adj;
        num      = bl_x - def_enq + sz_x;
        div_in   = (num > 0) ? DIV_W'(num - 1) : '0;
        upd      = ent;
        case (sel)
            OP_DEQ: begin
                upd.backlog  = ent.backlog - BYTES_W'(cur_size);
                upd.deficit  = DEF_W'(def_adj - sz_x);
                upd.last_rnd = cur_lat;
            end
            OP_ENQ: begin
                upd.deficit  = DEF_W'(def_enq);
                upd.last_rnd = fresh ? cur_lat : ent.last_rnd;
            end
            default: begin
                upd.backlog  = ent.backlog - BYTES_W'(cur_size);
            end
        endcase
        hold_w         = hold;
        hold_w.backlog = hold.backlog + BYTES_W'(ev_size[OP_ENQ]);
        div_start      = (state == ST_EXEC) && (sel == OP_ENQ);
        tbl_we         = ((state == ST_EXEC) && (sel != OP_ENQ)) ||
                         ((state == ST_DIV) && div_done);
        tbl_wd         = (state == ST_DIV) ? ENT_W'(hold_w) : ENT_W'(upd);
    end

    rau_flow_table #(.DEPTH(NUM_FLOWS), .WIDTH(ENT_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (ev_flow[sel]),
        .rd_data (tbl_rd),
        .we      (tbl_we),
        .wr_addr (ev_flow[sel]),
        .wr_data (tbl_wd)
    );

    rau_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_in),
        .divisor  (DIV_W'(quantum)),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend      <= '0;
            cur_lat   <= '0;
            hold      <= '0;
            idx_valid <= 1'b0;
            idx_out   <= '0;
            for (int i = 0; i < 3; i++) begin
                ev_flow[i] <= '0;
                ev_size[i] <= '0;
            end
        end else begin
            idx_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    pend        <= {drop_req, enq_req, deq_req};
                    ev_flow[0]  <= deq_flow;
                    ev_size[0]  <= deq_size;
                    ev_flow[1]  <= enq_flow;
                    ev_size[1]  <= enq_size;
                    ev_flow[2]  <= drop_flow;
                    ev_size[2]  <= drop_size;
                    cur_lat     <= cur_round;
                    state       <= ST_READ;
                end
                ST_READ: state <= ST_EXEC;
                ST_EXEC: begin
                    if (sel == OP_ENQ) begin
                        hold  <= upd;
                        state <= ST_DIV;
                    end else begin
                        pend  <= pend & ~sel_bit;
                        state <= more ? ST_READ : ST_IDLE;
                    end
                end
                default: if (div_done) begin
                    pend      <= pend & ~sel_bit;
                    idx_out   <= cur_lat + div_q[RND_W-1:0];
                    idx_valid <= 1'b1;
                    state     <= more ? ST_READ : ST_IDLE;
                end
            endcase
        end
    end

    // R9: an accepted event keeps the block busy in the following cycle
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R10: the index strobe lasts a single cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        idx_valid |=> !idx_valid);

    // R10: the strobe is raised only when the divider has just finished
    a_r10_valid_from_divider: assert property (@(posedge clk) disable iff (rst)
        $rose(idx_valid) |-> $past(div_done));

    // R9: the state table is never written while the block is idle
    a_r9_no_idle_write: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> busy);

    // R4: the divider is never restarted while it is still running
    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        div_start |-> !div_busy);

endmodule

// File: tb/sim_round_assign_unit.sv
module sim_round_assign_unit;

    localparam int NF = 8, NQ = 16, LM = 64, MW = 4;
    localparam int WT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]         cur_round = '0;
    logic [NF*WT_W-1:0] weights;
    logic               enq_req = 0, deq_req = 0, drop_req = 0;
    logic [2:0]         enq_flow = '0, deq_flow = '0, drop_flow = '0;
    logic [6:0]         enq_size = '0, deq_size = '0, drop_size = '0;
    logic               busy, idx_valid;
    logic [3:0]         idx_out;

    always #5 clk = ~clk;

    round_assign_unit #(.NUM_FLOWS(NF), .NUM_Q(NQ), .MAX_PKT(LM), .MAX_W(MW)) u0 (
        .clk(clk), .rst(rst), .cur_round(cur_round), .weights(weights),
        .enq_req(enq_req), .enq_flow(enq_flow), .enq_size(enq_size),
        .deq_req(deq_req), .deq_flow(deq_flow), .deq_size(deq_size),
        .drop_req(drop_req), .drop_flow(drop_flow), .drop_size(drop_size),
        .busy(busy), .idx_valid(idx_valid), .idx_out(idx_out)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    int m_w [NF] = '{1, 2, 1, 4, 1, 1, 1, 1};
    int m_bl [NF], m_def [NF], m_rnd [NF];
    int cur = 0;

    initial for (int f = 0; f < NF; f++) weights[f*WT_W +: WT_W] = 3'(m_w[f]);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void m_topup(input int f);
        if (m_rnd[f] != cur && m_def[f] < 0) m_def[f] += m_w[f] * LM;
    endfunction

    function automatic int m_enq(input int f, input int s);
        int q = m_w[f] * LM, n, off;
        if (m_bl[f] == 0) begin m_def[f] = 0; m_rnd[f] = cur; end
        else m_topup(f);
        n = m_bl[f] - m_def[f] + s;
        off = (n <= 0) ? 0 : (n - 1) / q;
        m_bl[f] += s;
        return (cur + off) % NQ;
    endfunction

    function automatic void m_deq(input int f, input int s);
        m_topup(f);
        m_bl[f] -= s; m_def[f] -= s; m_rnd[f] = cur;
    endfunction

    // Drives one batch, then waits for busy to fall, counting strobes.
    task automatic run_ev(input bit e, input int ef, input int es,
                          input bit d, input int df, input int ds,
                          input bit p, input int pf, input int ps,
                          output int got, output int pulses);
        @(negedge clk);
        cur_round = 4'(cur);
        enq_req = e;  enq_flow = 3'(ef);  enq_size = 7'(es);
        deq_req = d;  deq_flow = 3'(df);  deq_size = 7'(ds);
        drop_req = p; drop_flow = 3'(pf); drop_size = 7'(ps);
        @(negedge clk);
        enq_req = 0; deq_req = 0; drop_req = 0;
        got = -1; pulses = 0;
        for (int k = 0; k < 300; k++) begin
            if (idx_valid) begin pulses++; got = int'(idx_out); end
            if (!busy) break;
            @(negedge clk);
        end
        chk(busy == 1'b0, "R9 busy released", int'(busy), 0);
    endtask

    task automatic do_enq(input int f, input int s, input string req);
        int got, pl, exp;
        run_ev(1, f, s, 0, 0, 0, 0, 0, 0, got, pl);
        exp = m_enq(f, s);
        chk(pl == 1, "R10 one strobe per arrival", pl, 1);
        chk(got == exp, req, got, exp);
    endtask

    task automatic do_deq(input int f, input int s);
        int got, pl;
        run_ev(0, 0, 0, 1, f, s, 0, 0, 0, got, pl);
        m_deq(f, s);
        chk(pl == 0, "R10 no strobe on departure", pl, 0);
    endtask

    task automatic do_drop(input int f, input int s);
        int got, pl;
        run_ev(0, 0, 0, 0, 0, 0, 1, f, s, got, pl);
        m_bl[f] -= s;
        chk(pl == 0, "R10 no strobe on discard", pl, 0);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R11 busy low after reset", int'(busy), 0);
        chk(idx_valid == 1'b0, "R11 strobe low after reset", int'(idx_valid), 0);
    endtask

    task automatic t_new_and_accumulate;
        cur = 3;
        do_enq(0, 64, "R2 new flow index");
        do_enq(0, 64, "R5 backlog accumulates");
        do_enq(0, 10, "R4 ceiling of partial round");
    endtask

    task automatic t_weight;
        cur = 3;
        do_enq(1, 64, "R1 weight two first");
        do_enq(1, 64, "R1 weight two same round");
        do_enq(1, 64, "R1 weight two next round");
    endtask

    task automatic t_topup;
        cur = 3; do_deq(0, 64);
        cur = 4; do_enq(0, 20, "R3 top-up on new round");
        do_deq(0, 10);
        do_enq(0, 1, "R3 top-up at most once");
        cur = 5; do_deq(0, 64);
        do_enq(0, 64, "R6 departure charges credit");
    endtask

    task automatic t_same_cycle;
        int got, pl, exp;
        cur = 6;
        do_enq(4, 64, "R2 flow four first");
        run_ev(1, 4, 64, 1, 4, 64, 0, 0, 0, got, pl);
        m_deq(4, 64); exp = m_enq(4, 64);
        chk(got == exp, "R8 departure before arrival", got, exp);
        run_ev(1, 5, 64, 0, 0, 0, 1, 5, 64, got, pl);
        exp = m_enq(5, 64); m_bl[5] -= 64;
        chk(got == exp, "R8 arrival before discard", got, exp);
        do_enq(5, 64, "R8 discard applied last");
        cur = 7; do_deq(4, 64);
        do_enq(4, 64, "R2 drained flow is new again");
    endtask

    task automatic t_drop;
        cur = 8;
        for (int k = 0; k < 4; k++) do_enq(3, 64, "R1 weight four fills round");
        do_enq(3, 64, "R1 weight four overflows");
        do_drop(3, 64);
        do_enq(3, 64, "R7 discard reduces backlog");
        cur = 9; do_deq(3, 64);
        do_drop(3, 64);
        do_enq(3, 32, "R7 discard keeps credit");
    endtask

    task automatic t_wrap_clamp;
        cur = 15;
        do_enq(6, 64, "R4 last queue");
        do_enq(6, 64, "R4 index wraps");
        cur = 2;
        do_enq(7, 10, "R2 flow seven");
        do_enq(7, 10, "R4 small arrival");
        do_deq(7, 10);
        cur = 3;
        do_enq(7, 10, "R4 negative numerator clamps");
    endtask

    task automatic t_busy_ignored;
        int got = -1, pl = 0, exp;
        cur = 15;
        @(negedge clk);
        cur_round = 4'(cur);
        enq_req = 1; enq_flow = 3'd6; enq_size = 7'd1;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        enq_size = 7'd64;
        for (int k = 0; k < 4; k++) @(negedge clk);
        enq_req = 0;
        for (int k = 0; k < 300; k++) begin
            if (idx_valid) begin pl++; got = int'(idx_out); end
            if (!busy) break;
            @(negedge clk);
        end
        exp = m_enq(6, 1);
        chk(pl == 1, "R9 stray request ignored", pl, 1);
        chk(got == exp, "R9 first arrival index", got, exp);
        do_enq(6, 64, "R9 backlog untouched by stray request");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        for (int f = 0; f < NF; f++) begin m_bl[f] = 0; m_def[f] = 0; m_rnd[f] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_new_and_accumulate();
        t_weight();
        t_topup();
        t_same_cycle();
        t_drop();
        t_wrap_clamp();
        t_busy_ignored();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule